// File: doc/BRIEF.md
# Subword Mix and Permute Unit

This block rearranges the subwords of 64-bit operands without touching memory. It offers two kinds of operation. The first kind interleaves two sources: it takes alternating 16-bit subwords from each, or whole 32-bit halves. The second kind copies any 16-bit subword of a single source into any destination lane, and a subword may appear in more than one lane. A 3-bit selector picks the operation. An 8-bit control word steers the permute.

A request is presented with `in_valid` high. The result is registered and appears, with `res_valid` high, one clock later. Subwords are numbered 1 to 4 from the most significant end, so subword 1 is bits 63:48 and subword 4 is bits 15:0. In the text below, a1..a4 are the subwords of `src_a` and b1..b4 are those of `src_b`.

Top module: `subword_shuffle`

## Requirements
- R1: While `rst_n` is low and after its release, until the first request completes, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is high in exactly those cycles that follow a cycle in which `in_valid` was high. The result therefore comes one clock after the request.
- R3: Operation code 3'd0 gives, from the most significant lane down, a1, b1, a3, b3.
- R4: Operation code 3'd1 gives a2, b2, a4, b4.
- R5: Operation code 3'd2 gives the upper 32 bits of `src_a` above the upper 32 bits of `src_b`, that is a1, a2, b1, b2.
- R6: Operation code 3'd3 gives the lower 32 bits of `src_a` above the lower 32 bits of `src_b`, that is a3, a4, b3, b4.
- R7: Operation code 3'd4 is the permute. `perm_ctl[7:6]` steers destination subword 1, `[5:4]` steers subword 2, `[3:2]` steers subword 3 and `[1:0]` steers subword 4. A field value v copies source subword v+1 of `src_a`, so 8'b00_01_10_11 returns `src_a` unchanged and 8'b11_10_01_00 reverses its lanes.
- R8: In a permute, two or more fields may hold the same value, and that source subword is then copied into every lane that selects it (for example, 8'h00 fills all four lanes with a1).
- R9: In a permute, `src_b` has no effect on the result.
- R10: Operation codes 3'd5, 3'd6 and 3'd7 produce an all-zero result, and `res_valid` is still asserted.
- R11: `res_data` keeps its last value in every cycle that does not follow a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| perm_ctl | input | 8 | Four 2-bit lane selectors for the permute |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_data | output | 64 | Registered result |

## Verification
The bench builds the unit with its default 16-bit lane width, which gives four lanes and a 64-bit word. At this width every one of the 256 permute control values, including each duplicated-lane pattern, is valid stimulus. The bench applies every control value to one source, so that any miswired selector field shows up.

The operand values are chosen so that each 16-bit subword is distinct, which makes a swapped lane visible in the result. Back-to-back requests are mixed with idle gaps to exercise the strobe timing and the hold behaviour. A permute is repeated with several values on `src_b` to check that the second source has no effect.

// File: rtl/subword_shuffle.sv
module subword_shuffle #(
  parameter int LANE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [2:0]            op,
  input  logic [4*LANE_W-1:0]   src_a,
  input  logic [4*LANE_W-1:0]   src_b,
  input  logic [7:0]            perm_ctl,
  output logic                  res_valid,
  output logic [4*LANE_W-1:0]   res_data
);
  localparam int LANES  = 4;
  localparam int SEL_W  = 2;
  localparam int WORD_W = LANES * LANE_W;
  localparam int HALF_W = WORD_W / 2;

  localparam logic [2:0] OP_MIX16_L = 3'd0;
  localparam logic [2:0] OP_MIX16_R = 3'd1;
  localparam logic [2:0] OP_MIX32_L = 3'd2;
  localparam logic [2:0] OP_MIX32_R = 3'd3;
  localparam logic [2:0] OP_PERM    = 3'd4;

  logic [LANE_W-1:0] a_l [LANES];
  logic [LANE_W-1:0] b_l [LANES];
  logic [LANE_W-1:0] p_l [LANES];
  logic [WORD_W-1:0] perm_w, nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [SEL_W-1:0] sel;
    assign a_l[i] = src_a[WORD_W-1-i*LANE_W -: LANE_W];
    assign b_l[i] = src_b[WORD_W-1-i*LANE_W -: LANE_W];
    assign sel    = perm_ctl[LANES*SEL_W-1-i*SEL_W -: SEL_W];
    assign p_l[i] = a_l[sel];
    assign perm_w[WORD_W-1-i*LANE_W -: LANE_W] = p_l[i];
  end

  always_comb begin
    case (op)
      OP_MIX16_L: nxt = {a_l[0], b_l[0], a_l[2], b_l[2]};
      OP_MIX16_R: nxt = {a_l[1], b_l[1], a_l[3], b_l[3]};
      OP_MIX32_L: nxt = {src_a[WORD_W-1 -: HALF_W], src_b[WORD_W-1 -: HALF_W]};
      OP_MIX32_R: nxt = {src_a[HALF_W-1:0], src_b[HALF_W-1:0]};
      OP_PERM:    nxt = perm_w;
      default:    nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= nxt;
    end
  end
endmodule

// File: rtl/subword_shuffle_chk.sv
module subword_shuffle_chk #(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [2:0]          op,
  input logic [4*LANE_W-1:0] src_a,
  input logic [4*LANE_W-1:0] src_b,
  input logic [7:0]          perm_ctl,
  input logic                res_valid,
  input logic [4*LANE_W-1:0] res_data
);
  localparam int WORD_W = 4 * LANE_W;
  localparam int HALF_W = WORD_W / 2;

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  p_mix32_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2) |=>
      res_data == {$past(src_a[WORD_W-1 -: HALF_W]), $past(src_b[WORD_W-1 -: HALF_W])});
  p_perm_identity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4 && perm_ctl == 8'h1B) |=> res_data == $past(src_a));
  p_bad_op_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op > 3'd4) |=> (res_data == '0 && res_valid));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data));
endmodule

bind subword_shuffle subword_shuffle_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
  .src_a(src_a), .src_b(src_b), .perm_ctl(perm_ctl),
  .res_valid(res_valid), .res_data(res_data)
);

// File: tb/subword_shuffle_bench.sv
`timescale 1ns/1ps
module subword_shuffle_bench;
  localparam int LW = 16;
  localparam int W  = 4 * LW;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] src_a = '0, src_b = '0;
  logic [7:0]   perm_ctl = '0;
  logic         res_valid;
  logic [W-1:0] res_data;

  int applied = 0;
  int fails = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  logic [W-1:0] last_res = '0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  subword_shuffle u_subword_shuffle (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .src_a(src_a), .src_b(src_b), .perm_ctl(perm_ctl),
    .res_valid(res_valid), .res_data(res_data)
  );

  function automatic logic [LW-1:0] sub(logic [W-1:0] x, int idx);
    return x[W - (idx - 1) * LW - 1 -: LW];
  endfunction

  function automatic logic [W-1:0] model(logic [2:0] o, logic [W-1:0] a,
                                         logic [W-1:0] b, logic [7:0] c);
    logic [W-1:0] r;
    r = '0;
    case (o)
      3'd0: r = {sub(a,1), sub(b,1), sub(a,3), sub(b,3)};
      3'd1: r = {sub(a,2), sub(b,2), sub(a,4), sub(b,4)};
      3'd2: r = {sub(a,1), sub(a,2), sub(b,1), sub(b,2)};
      3'd3: r = {sub(a,3), sub(a,4), sub(b,3), sub(b,4)};
      3'd4: r = {sub(a, int'(c[7:6]) + 1), sub(a, int'(c[5:4]) + 1),
                 sub(a, int'(c[3:2]) + 1), sub(a, int'(c[1:0]) + 1)};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [2:0] o, logic [W-1:0] a, logic [W-1:0] b,
                       logic [7:0] c, string req);
    @(negedge clk);
    in_valid = 1'b1; op = o; src_a = a; src_b = b; perm_ctl = c;
    exp_q.push_back(model(o, a, b, c));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; src_a = ~src_a; src_b = ~src_b;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (res_valid) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected res_valid", {{(W-1){1'b0}}, res_valid}, '0);
          end else begin
            logic [W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(res_data === e, t, res_data, e);
            last_res = e;
          end
        end else begin
          check(res_data === last_res, "R11 hold while idle", res_data, last_res);
        end
      end
    end
  end

  // watchdog
  initial begin
    #500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  localparam logic [W-1:0] A0 = 64'h1111_2222_3333_4444;
  localparam logic [W-1:0] B0 = 64'hAAAA_BBBB_CCCC_DDDD;
  localparam logic [W-1:0] A1 = 64'hDEAD_BEEF_0123_4567;
  localparam logic [W-1:0] B1 = 64'h89AB_CDEF_FEDC_BA98;

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid === 1'b0, "R1 reset valid", {{(W-1){1'b0}}, res_valid}, '0);
    check(res_data === '0, "R1 reset data", res_data, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(res_valid === 1'b0 && res_data === '0, "R1 after release", res_data, '0);

    drive(3'd0, A0, B0, 8'h00, "R3 mix16 left");
    drive(3'd1, A0, B0, 8'h00, "R4 mix16 right");
    drive(3'd2, A0, B0, 8'h00, "R5 mix32 left");
    drive(3'd3, A0, B0, 8'h00, "R6 mix32 right");
    idle(2);
    drive(3'd0, A1, B1, 8'hFF, "R3 mix16 left pattern 2");
    idle(1);
    drive(3'd1, A1, B1, 8'hFF, "R4 mix16 right pattern 2");
    drive(3'd2, B1, A1, 8'h55, "R5 mix32 left pattern 2");
    drive(3'd3, B1, A1, 8'h55, "R6 mix32 right pattern 2");
    drive(3'd4, A0, B0, 8'b00_01_10_11, "R7 permute identity");
    drive(3'd4, A0, B0, 8'b11_10_01_00, "R7 permute reverse");
    drive(3'd4, A1, B0, 8'h00, "R8 permute all lane 1");
    drive(3'd4, A1, B0, 8'hFF, "R8 permute all lane 4");
    drive(3'd4, A1, B0, 8'b01_01_10_10, "R8 permute pairs");
    drive(3'd4, A0, 64'h0, 8'h4E, "R9 permute src_b zero");
    drive(3'd4, A0, '1, 8'h4E, "R9 permute src_b ones");
    drive(3'd4, A0, B1, 8'h4E, "R9 permute src_b pattern");
    drive(3'd5, A0, B0, 8'h1B, "R10 op 5 zero");
    drive(3'd6, A1, B1, 8'h1B, "R10 op 6 zero");
    idle(1);
    drive(3'd7, A1, B1, 8'h1B, "R10 op 7 zero");
    drive(3'd0, A0, B1, 8'h00, "R3 after zero op");
    idle(3);
    for (int c = 0; c < 256; c++) begin
      drive(3'd4, A1, B0, 8'(c), "R7 permute sweep");
    end
    idle(4);
    check(exp_q.size() == 0, "R2 missing results", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule